// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block sits between one asynchronous external interrupt pin and the interrupt controller. The pin is first brought into the system clock domain. An optional pulse-width qualifier then treats any level that does not stay put for a full qualification window as noise. On the conditioned level, the block looks for the edge polarity that the caller has selected and raises a single-cycle request strobe. That strobe is meant to set the external interrupt flag.

Two inputs decide whether the qualifier is used. The first is a static configuration option that turns qualification on or off. The second is a flag that says the system runs from a slow crystal. When that flag is set, the qualifier is forced out of the path and the synchronised level is used directly. Edge polarity comes from a run-time control bit. A change to that bit takes effect from the following clock, and a change of polarity never fakes an edge.

Top module: `extint_conditioner`

## Requirements
- R1: While reset is low, and for as long as the pin holds its level after reset is released, `irq_req_o` stays 0. The conditioned level starts out equal to the synchronised pin, so leaving reset reports no edge.
- R2: With qualification active (`filt_opt_i`=1, `slow_xtal_i`=0), a pin pulse that lasts fewer than 8 clock cycles produces no request.
- R3: With qualification active, a pin level that holds for 8 or more cycles yields exactly one request, provided the change matches the selected polarity.
- R4: With qualification active, a matching pin change made before clock edge 1 shows up as `irq_req_o`=1 after clock edge 11, and not after clock edge 10.
- R5: With `filt_opt_i`=0, a pin pulse one cycle wide yields one request. It is seen after clock edge 3 following the change, and not after edge 2.
- R6: With `slow_xtal_i`=1, qualification is bypassed even when `filt_opt_i`=1. A 2-cycle pulse then yields one request.
- R7: `fall_sel_i`=0 selects rising edges of the conditioned level. `fall_sel_i`=1 selects falling edges. An edge of the other polarity produces no request.
- R8: Changing `fall_sel_i` while the conditioned level is steady produces no request. The new polarity applies to edges judged from the clock after the change.
- R9: Each qualifying edge of the conditioned level gives a request that lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 1 | Raw asynchronous interrupt pin |
| fall_sel_i | input | 1 | Edge select: 0 rising, 1 falling |
| filt_opt_i | input | 1 | Configuration option: 1 enables pulse qualification |
| slow_xtal_i | input | 1 | 1 when running from the slow crystal; forces bypass |
| irq_req_o | output | 1 | One-cycle external interrupt request |

## Verification
The polarity update and the completion of a qualification window can land on the same clock. In that cycle the polarity that was registered before the change has to decide the outcome. The bench provokes this by sweeping the moment `fall_sel_i` flips across several cycle offsets around the point where a qualified level change completes. A behavioural reference model, stepped on every clock, then decides whether that level change should have raised a request, and the output is compared with it. Mode switches between filtered and bypassed operation are exercised in the same way, to confirm that no stray edge appears when the qualifier leaves or rejoins the path.

// File: rtl/extint_conditioner.sv
module extint_conditioner #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  input  logic filt_opt_i,
  input  logic slow_xtal_i,
  output logic irq_req_o
);
  localparam int CNT_W = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_sync;
  logic                   bypass;
  logic                   lvl_filt;
  logic [CNT_W-1:0]       run_cnt;
  logic                   lvl_eff;
  logic                   lvl_prev;
  logic                   fall_sel_q;

  always_ff @(posedge clk) sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};

  assign pin_sync = sync_q[SYNC_STAGES-1];
  assign bypass   = !filt_opt_i || slow_xtal_i;

  always_ff @(posedge clk) begin
    if (!rst_n || bypass) begin
      lvl_filt <= pin_sync;
      run_cnt  <= '0;
    end else if (pin_sync == lvl_filt) begin
      run_cnt  <= '0;
    end else if (run_cnt == CNT_LAST) begin
      lvl_filt <= pin_sync;
      run_cnt  <= '0;
    end else begin
      run_cnt  <= run_cnt + 1'b1;
    end
  end

  assign lvl_eff = bypass ? pin_sync : lvl_filt;

  always_ff @(posedge clk) begin
    fall_sel_q <= fall_sel_i;
    if (!rst_n) begin
      lvl_prev  <= pin_sync;
      irq_req_o <= 1'b0;
    end else begin
      lvl_prev  <= lvl_eff;
      irq_req_o <= (lvl_eff != lvl_prev) && (lvl_eff != fall_sel_q);
    end
  end
endmodule

// File: rtl/extint_conditioner_chk.sv
module extint_conditioner_chk #(
  parameter int FILT_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic irq_req_o,
  input logic pin_sync,
  input logic lvl_filt,
  input logic lvl_eff,
  input logic lvl_prev,
  input logic fall_sel_q,
  input logic bypass
);
  logic       sync_d;
  logic       filt_d;
  logic       byp_d;
  logic       rst_d;
  logic [7:0] run;

  always_ff @(posedge clk) begin
    sync_d <= pin_sync;
    filt_d <= lvl_filt;
    byp_d  <= bypass;
    rst_d  <= rst_n;
    if (pin_sync != sync_d) run <= 8'd1;
    else if (run != 8'hff)  run <= run + 8'd1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_req_o);

  // R2
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_d && !byp_d && lvl_filt != filt_d) |-> run >= 8'(FILT_CYCLES));

  // R7
  polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> ($past(lvl_eff) != $past(fall_sel_q)));

  // R8
  real_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> ($past(lvl_eff) != $past(lvl_prev)));

  // R9
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> lvl_prev == $past(lvl_eff));
endmodule

bind extint_conditioner extint_conditioner_chk #(.FILT_CYCLES(FILT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req_o(irq_req_o), .pin_sync(pin_sync),
  .lvl_filt(lvl_filt), .lvl_eff(lvl_eff), .lvl_prev(lvl_prev),
  .fall_sel_q(fall_sel_q), .bypass(bypass)
);

// File: tb/test_extint_conditioner.sv
`timescale 1ns/1ps
module test_extint_conditioner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1, fsel = 1'b0, fopt = 1'b1, slow = 1'b0;
  logic irq;

  extint_conditioner i_extint_conditioner (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .fall_sel_i(fsel),
    .filt_opt_i(fopt), .slow_xtal_i(slow), .irq_req_o(irq)
  );

  always #4 clk = ~clk;

  int    vectors = 0, fails = 0, win = 0;
  bit    finished = 0;
  string tag = "R1";

  bit m_s1, m_s2, m_filt, m_prev, m_sel, m_req;
  int m_run;
  logic q_pin[$];

  always @(posedge clk) begin
    bit byp, lvl, nreq, nfilt, nprev;
    byp  = !fopt || slow;
    lvl  = byp ? m_s2 : m_filt;
    nreq = rst_n && (lvl != m_prev) && (lvl == !m_sel);
    nfilt = m_filt;
    if (!rst_n || byp) begin nfilt = m_s2; m_run = 0; end
    else if (m_s2 != m_filt) begin
      m_run++;
      if (m_run == 8) begin nfilt = m_s2; m_run = 0; end
    end else m_run = 0;
    nprev = rst_n ? lvl : m_s2;
    q_pin.push_back(pin);
    if (q_pin.size() > 2) void'(q_pin.pop_front());
    m_s2 = m_s1; m_s1 = pin;
    m_filt = nfilt; m_prev = nprev; m_sel = fsel; m_req = nreq;
  end

  always @(negedge clk) begin
    if (irq === 1'b1) win++;
    if (rst_n && !finished) begin
      vectors++;
      if (irq !== m_req) begin
        fails++;
        $display("FAIL %s model compare: got %b expected %b at %0t", tag, irq, m_req, $time);
      end
    end
  end

  task automatic chk(input int got, input int exp, input string t);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", t, got, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit v, input int w, input int gap);
    pin = v; idle(w); pin = !v; idle(gap);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle(6);
    chk(irq, 0, "R1 during reset");
    rst_n = 1'b1;
    win = 0; idle(20);
    chk(win, 0, "R1 after reset");

    tag = "R7";
    win = 0; pin = 0; idle(20);
    chk(win, 0, "R7 falling ignored with rising selected");

    tag = "R2";
    win = 0;
    for (int w = 1; w < 8; w++) pulse(1'b1, w, 14);
    chk(win, 0, "R2 short pulses rejected");

    tag = "R3";
    win = 0; pulse(1'b1, 8, 20);
    chk(win, 1, "R3 8-cycle pulse accepted");
    win = 0; pulse(1'b1, 15, 20);
    chk(win, 1, "R3 long pulse accepted once");

    tag = "R4";
    pin = 1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i == 10) chk(irq, 0, "R4 not before edge 11");
      if (i == 11) chk(irq, 1, "R4 request after edge 11");
      if (i == 12) chk(irq, 0, "R9 single cycle");
    end
    idle(10);

    tag = "R7";
    fsel = 1; idle(3);
    win = 0; pin = 0; idle(20);
    chk(win, 1, "R7 falling edge selected");
    win = 0; pin = 1; idle(20);
    chk(win, 0, "R7 rising ignored with falling selected");

    tag = "R8";
    win = 0;
    for (int i = 0; i < 10; i++) begin fsel = !fsel; idle(i % 3 + 1); end
    fsel = 1; idle(3);
    chk(win, 0, "R8 select toggling alone");
    for (int k = 7; k <= 12; k++) begin
      fsel = 1; pin = 1; idle(20);
      pin = 0; idle(k); fsel = 0; idle(20);
    end
    for (int k = 7; k <= 12; k++) begin
      fsel = 0; pin = 0; idle(20);
      pin = 1; idle(k); fsel = 1; idle(20);
    end
    fsel = 0; pin = 0; idle(20);

    tag = "R5";
    fopt = 0; idle(5);
    win = 0;
    pin = 1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i == 1) pin = 0;
      if (i == 2) chk(irq, 0, "R5 not before edge 3");
      if (i == 3) chk(irq, 1, "R5 bypass request after edge 3");
      if (i == 4) chk(irq, 0, "R9 bypass single cycle");
    end
    idle(10);
    chk(win, 1, "R5 one request for 1-cycle pulse");

    tag = "R6";
    fopt = 1; slow = 1; idle(5);
    win = 0; pulse(1'b1, 2, 15);
    chk(win, 1, "R6 slow crystal bypass");
    slow = 0; idle(5);
    win = 0; pulse(1'b1, 2, 15);
    chk(win, 0, "R2 filter back after slow crystal");

    tag = "R9";
    fopt = 0; win = 0;
    for (int i = 0; i < 5; i++) pulse(1'b1, 1, 1);
    idle(8);
    chk(win, 5, "R9 one strobe per bypassed edge");
    fopt = 1; idle(20);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule